// File: doc/BRIEF.md
# Channel Status and Sample-Rate Reporter

This block sits behind a digital audio frame decoder. Once per frame it takes one channel status bit from each of the two subframes, keeps the bit stream of the channel picked by `chan_sel_i`, and at every block start shows the first sixteen status bits of the block just finished on six reporting pins. The meaning of five of those pins depends on status bit 0: it tells professional from consumer format. A block is `BLOCK_FRAMES` frames long, 192 by default. The block also drives `cbl_o`, a block marker that rises one cycle after the block-start frame.

When `sel_i` is low, the same six pins switch to a second view. The upper three pins carry a prioritised error code. The lower three carry a sample-rate code. The rate code comes from counting reference-clock enable pulses over windows of `WIN_FRAMES` frames, 64 by default. Three windows make up a block, and the first window begins at the block boundary. A rate is reported only after enough complete windows with reference activity have passed. `ref_tick_i` is a synchronous one-cycle enable for each reference-clock period of `REF_HZ`.

Top module: `cs_report_top`

## Requirements
- R1: With `sel_i`=1, `pins_o[5]` shows latched status bit 0. The value 0 means professional format and 1 means consumer format.
- R2: Status bits are taken from subframe A (`cs_a_i`) when `chan_sel_i`=0 and from subframe B (`cs_b_i`) when `chan_sel_i`=1. The channel in use is the one selected at the frame in which each bit arrives.
- R3: With `sel_i`=1, `pins_o[4:0]` show status bits 1, 2, 3, 15 and 9 (in that order, MSB first) in consumer format, and bits 1, 2, 3, 4 and 6 in professional format.
- R4: The status view changes only in the cycle after a frame with `blk_start_i`=1. It then shows bits 0..15 of the block that preceded that frame. Frame k of a block carries bit k, and the block-start frame is frame 0.
- R5: `cbl_o` rises in the cycle after a block-start frame. It stays high until the cycle after frame `CBL_FRAMES` (32) of the block, and then falls. It is low out of reset.
- R6: The rate code changes only in the cycle after frame 0, 64 or 128 of a block. The codes are 001=32, 010=44.1, 011=48, 100=88.2 and 101=96 kHz, and the measured window must lie within ±4 % of nominal.
- R7: The rate code is 000 when the window count matches no rate. It is also 000 until two consecutive complete windows have each seen at least one reference tick.
- R8: With `sel_i`=0, `pins_o[5:3]` show an error code taken at each frame, in this priority: lock loss 100, biphase 011, parity 010, validity 001, none 000.
- R9: With `sel_i`=0, `pins_o[2:0]` show the rate code.
- R10: Out of reset, all latched state is zero, so `pins_o` reads 000000 in both views.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle pulse per received frame |
| blk_start_i | input | 1 | Frame carries the block-start preamble (qualified by frame_valid_i) |
| cs_a_i | input | 1 | Channel status bit of subframe A |
| cs_b_i | input | 1 | Channel status bit of subframe B |
| chan_sel_i | input | 1 | Status channel select, 0=A, 1=B |
| sel_i | input | 1 | View select, 1=status bits, 0=error and rate |
| ref_tick_i | input | 1 | Reference clock enable, one pulse per reference period |
| lock_lost_i | input | 1 | Receiver out of lock |
| biphase_err_i | input | 1 | Biphase coding violation in frame |
| parity_err_i | input | 1 | Parity error in frame |
| validity_i | input | 1 | Validity flag of frame |
| pins_o | output | 6 | Six reporting pins |
| cbl_o | output | 1 | Block marker |

## Verification
Every cycle, the assertions check that the status view moves only after a block-start frame and the rate code only after a window boundary. They also check that the block marker rises only after a start frame, that the rate code stays in its legal set and is non-zero only once enough windows have passed, and that lock loss always wins the error code. Only the bench scenarios can show that the right bits land on the right pins in each format and from each channel, and that the measured rates map to the right codes at several frame periods. The bench also shows the two-window settling after reset and after loss of the reference.

// File: rtl/cs_report_pkg.sv
package cs_report_pkg;
  localparam int CS_BITS  = 16;
  localparam int N_MAPPED = 5;
  localparam int N_RATES  = 5;

  // status bit shown on pins_o[4-g], per format
  localparam int PRO_MAP [N_MAPPED] = '{1, 2, 3, 4, 6};
  localparam int CON_MAP [N_MAPPED] = '{1, 2, 3, 15, 9};

  localparam longint RATE_HZ [N_RATES] = '{32000, 44100, 48000, 88200, 96000};

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_VALID   = 3'd1,
    ERR_PARITY  = 3'd2,
    ERR_BIPHASE = 3'd3,
    ERR_LOCK    = 3'd4
  } err_code_e;
endpackage

// File: rtl/cs_block_timer.sv
module cs_block_timer #(
  parameter int BLOCK_FRAMES = 192,
  parameter int WIN_FRAMES   = 64,
  parameter int CBL_FRAMES   = 32,
  localparam int IDX_W = $clog2(BLOCK_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic             blk_start_i,
  output logic [IDX_W-1:0] new_idx_o,
  output logic             start_evt_o,
  output logic             boundary_o,
  output logic             cbl_o
);
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    if (blk_start_i || 32'(idx_q) == BLOCK_FRAMES - 1) new_idx_o = '0;
    else new_idx_o = idx_q + 1'b1;
  end

  assign start_evt_o = frame_valid_i && blk_start_i;
  assign boundary_o  = frame_valid_i && ((32'(new_idx_o) % WIN_FRAMES) == 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cbl_o <= 1'b0;
    end else if (frame_valid_i) begin
      idx_q <= new_idx_o;
      if (blk_start_i) cbl_o <= 1'b1;
      else if (32'(new_idx_o) == CBL_FRAMES) cbl_o <= 1'b0;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < BLOCK_FRAMES); // R6
  AST_CBL_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cbl_o) |-> $past(start_evt_o)); // R5
endmodule

// File: rtl/cs_status_capture.sv
module cs_status_capture
  import cs_report_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic [IDX_W-1:0] new_idx_i,
  input  logic             start_evt_i,
  input  logic             chan_sel_i,
  input  logic             cs_a_i,
  input  logic             cs_b_i,
  output logic [5:0]       cs_pins_o
);
  localparam int BIT_W = $clog2(CS_BITS);

  logic [CS_BITS-1:0] buf_q, disp_q;
  logic               bit_in;

  assign bit_in = chan_sel_i ? cs_b_i : cs_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      disp_q <= '0;
    end else begin
      if (start_evt_i) disp_q <= buf_q;  // previous block, before frame 0 overwrites
      if (frame_valid_i && 32'(new_idx_i) < CS_BITS) buf_q[new_idx_i[BIT_W-1:0]] <= bit_in;
    end
  end

  assign cs_pins_o[5] = disp_q[0];
  for (genvar g = 0; g < N_MAPPED; g++) begin : g_map
    assign cs_pins_o[N_MAPPED-1-g] = disp_q[0] ? disp_q[CON_MAP[g]] : disp_q[PRO_MAP[g]];
  end

  AST_DISP_ONLY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_evt_i |=> $stable(disp_q)); // R4
endmodule

// File: rtl/cs_rate_meter.sv
module cs_rate_meter
  import cs_report_pkg::*;
#(
  parameter int     BLOCK_FRAMES = 192,
  parameter int     WIN_FRAMES   = 64,
  parameter longint REF_HZ       = 768000,
  parameter int     CNT_W        = 16,
  localparam int    WF_W         = $clog2(WIN_FRAMES + 1),
  localparam int    VALID_WINS   = (2 * BLOCK_FRAMES + 3 * WIN_FRAMES - 1) / (3 * WIN_FRAMES),
  localparam int    OK_W         = $clog2(VALID_WINS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_valid_i,
  input  logic       boundary_i,
  input  logic       ref_tick_i,
  output logic [2:0] code_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [WF_W-1:0]  wf_q;
  logic [OK_W-1:0]  ok_q, ok_n;
  logic [2:0]       code_q, match;
  logic [N_RATES-1:0] hit;
  logic             full;

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam longint NOM = (REF_HZ * WIN_FRAMES) / RATE_HZ[g];
    localparam longint LO  = (NOM * 96) / 100;
    localparam longint HI  = (NOM * 104) / 100;
    assign hit[g] = (longint'(cnt_q) >= LO) && (longint'(cnt_q) <= HI);
  end

  always_comb begin
    match = 3'd0;
    for (int i = N_RATES - 1; i >= 0; i--) if (hit[i]) match = 3'(i + 1);
  end

  assign full = (32'(wf_q) == WIN_FRAMES) && (cnt_q != '0);

  always_comb begin
    if (!full) ok_n = '0;
    else if (32'(ok_q) == VALID_WINS) ok_n = ok_q;
    else ok_n = ok_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wf_q   <= '0;
      ok_q   <= '0;
      code_q <= '0;
    end else if (boundary_i) begin
      cnt_q  <= CNT_W'(ref_tick_i);
      wf_q   <= WF_W'(1);
      ok_q   <= ok_n;
      code_q <= (32'(ok_n) == VALID_WINS) ? match : 3'd0;
    end else begin
      if (ref_tick_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (frame_valid_i && 32'(wf_q) != WIN_FRAMES) wf_q <= wf_q + 1'b1;
    end
  end

  assign code_o = code_q;

  AST_CODE_ONLY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(code_q)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= 3'd5); // R6
  AST_CODE_NEEDS_WINDOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q != 3'd0 |-> 32'(ok_q) == VALID_WINS); // R7
endmodule

// File: rtl/cs_report_top.sv
module cs_report_top
  import cs_report_pkg::*;
#(
  parameter int     BLOCK_FRAMES = 192,
  parameter int     WIN_FRAMES   = 64,
  parameter int     CBL_FRAMES   = 32,
  parameter longint REF_HZ       = 768000,
  parameter int     CNT_W        = 16,
  localparam int    IDX_W        = $clog2(BLOCK_FRAMES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_valid_i,
  input  logic       blk_start_i,
  input  logic       cs_a_i,
  input  logic       cs_b_i,
  input  logic       chan_sel_i,
  input  logic       sel_i,
  input  logic       ref_tick_i,
  input  logic       lock_lost_i,
  input  logic       biphase_err_i,
  input  logic       parity_err_i,
  input  logic       validity_i,
  output logic [5:0] pins_o,
  output logic       cbl_o
);
  logic [IDX_W-1:0] new_idx;
  logic             start_evt, boundary;
  logic [5:0]       cs_pins;
  logic [2:0]       rate_code;
  err_code_e        err_q, err_n;

  cs_block_timer #(
    .BLOCK_FRAMES(BLOCK_FRAMES), .WIN_FRAMES(WIN_FRAMES), .CBL_FRAMES(CBL_FRAMES)
  ) u_timer (
    .clk_i, .rst_ni, .frame_valid_i, .blk_start_i,
    .new_idx_o(new_idx), .start_evt_o(start_evt), .boundary_o(boundary), .cbl_o
  );

  cs_status_capture #(.IDX_W(IDX_W)) u_capture (
    .clk_i, .rst_ni, .frame_valid_i, .new_idx_i(new_idx), .start_evt_i(start_evt),
    .chan_sel_i, .cs_a_i, .cs_b_i, .cs_pins_o(cs_pins)
  );

  cs_rate_meter #(
    .BLOCK_FRAMES(BLOCK_FRAMES), .WIN_FRAMES(WIN_FRAMES), .REF_HZ(REF_HZ), .CNT_W(CNT_W)
  ) u_rate (
    .clk_i, .rst_ni, .frame_valid_i, .boundary_i(boundary), .ref_tick_i, .code_o(rate_code)
  );

  always_comb begin
    if (lock_lost_i)        err_n = ERR_LOCK;
    else if (biphase_err_i) err_n = ERR_BIPHASE;
    else if (parity_err_i)  err_n = ERR_PARITY;
    else if (validity_i)    err_n = ERR_VALID;
    else                    err_n = ERR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= ERR_NONE;
    else if (frame_valid_i) err_q <= err_n;
  end

  assign pins_o = sel_i ? cs_pins : {err_q, rate_code};

  AST_LOCK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i && lock_lost_i |=> err_q == ERR_LOCK); // R8
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> $stable(err_q)); // R8
endmodule

// File: tb/tb_cs_report_top.sv
module tb_cs_report_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_valid_i = 0, blk_start_i = 0, cs_a_i = 0, cs_b_i = 0, chan_sel_i = 0;
  logic sel_i = 1, ref_tick_i = 1;
  logic lock_lost_i = 0, biphase_err_i = 0, parity_err_i = 0, validity_i = 0;
  logic [5:0] pins_o;
  logic cbl_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cs_report_top dut (
    .clk_i(clk), .rst_ni, .frame_valid_i, .blk_start_i, .cs_a_i, .cs_b_i, .chan_sel_i,
    .sel_i, .ref_tick_i, .lock_lost_i, .biphase_err_i, .parity_err_i, .validity_i,
    .pins_o, .cbl_o
  );

  // {chan_sel, word A, word B, expected status pins}; word bit k = status bit k
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 16'h0000, 16'hFFFF, 6'b000000},  // R3 professional, zero
    {1'b1, 16'h0000, 16'hFFFF, 6'b111111},  // R2 channel B, consumer
    {1'b0, 16'h8001, 16'h0000, 6'b100010},  // R3 consumer bit 15
    {1'b0, 16'h0201, 16'h0000, 6'b100001},  // R3 consumer bit 9
    {1'b0, 16'h0050, 16'h0000, 6'b000011},  // R3 professional bits 4,6
    {1'b0, 16'h8200, 16'h0000, 6'b000000},  // R3 consumer bits unseen in professional
    {1'b0, 16'h000E, 16'h0000, 6'b011100},  // R1 bits 1..3
    {1'b1, 16'h8200, 16'h0051, 6'b100000}   // R2 channel B, A ignored
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic frame(input logic st, input logic ba, input logic bb, input int n);
    frame_valid_i = 1'b1; blk_start_i = st; cs_a_i = ba; cs_b_i = bb;
    @(negedge clk);
    frame_valid_i = 1'b0; blk_start_i = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic run_frames(input int from, input int to, input int n);
    for (int i = from; i <= to; i++) frame(i == 0, 1'b0, 1'b0, n);
  endtask

  task automatic cs_block(input logic [15:0] a, input logic [15:0] b, input bit chk,
                          input logic [5:0] exp);
    for (int i = 0; i < 192; i++) begin
      frame(i == 0, (i < 16) ? a[i] : 1'b0, (i < 16) ? b[i] : 1'b0, 4);
      if (chk && i == 0)  check("R4 latch at start", pins_o, exp);
      if (chk && i == 20) check("R4 held mid-block", pins_o, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] prev;
    prev = '0;
    repeat (2) @(negedge clk);
    check("R10 reset status view", pins_o, 6'b000000);
    rst_ni = 1'b1;
    @(negedge clk);
    sel_i = 1'b0;
    #1 check("R10 reset error view", pins_o, 6'b000000);
    check("R5 cbl low out of reset", {5'b0, cbl_o}, 6'b000000);
    sel_i = 1'b1;

    // status table walk (R1 R2 R3 R4)
    for (int v = 0; v < 8; v++) begin
      chan_sel_i = VEC[v][38];
      cs_block(VEC[v][37:22], VEC[v][21:6], v > 0, prev);
      prev = VEC[v][5:0];
    end
    frame(1'b1, 1'b0, 1'b0, 4);
    check("R1 R3 last vector", pins_o, prev);
    sel_i = 1'b0;
    #1 check("R9 view switch leaves status", {pins_o[5:3], 3'b000}, 6'b000000);

    // rate measurement (R5 R6 R7 R9)
    do_reset();
    ref_tick_i = 1'b1;
    frame(1'b1, 1'b0, 1'b0, 16);
    check("R5 cbl high after start", {5'b0, cbl_o}, 6'b000001);
    check("R7 no code after partial window", pins_o, 6'b000000);
    run_frames(1, 31, 16);
    check("R5 cbl high at frame 31", {5'b0, cbl_o}, 6'b000001);
    run_frames(32, 32, 16);
    check("R5 cbl low after frame 32", {5'b0, cbl_o}, 6'b000000);
    run_frames(33, 64, 16);
    check("R7 one window only", pins_o, 6'b000000);
    run_frames(65, 127, 16);
    check("R6 no update mid-window", pins_o, 6'b000000);
    run_frames(128, 128, 16);
    check("R6 R9 48k code", pins_o, 6'b000011);
    run_frames(129, 191, 16);
    run_frames(0, 0, 8);
    check("R6 48k at block boundary", pins_o, 6'b000011);
    run_frames(1, 63, 8);
    check("R6 held before frame 64", pins_o, 6'b000011);
    run_frames(64, 64, 24);
    check("R6 96k code", pins_o, 6'b000101);
    run_frames(65, 127, 24);
    run_frames(128, 128, 12);
    check("R6 32k code", pins_o, 6'b000001);
    run_frames(129, 191, 12);
    ref_tick_i = 1'b0;
    run_frames(0, 0, 16);
    check("R7 out of range gives 000", pins_o, 6'b000000);
    run_frames(1, 63, 16);
    ref_tick_i = 1'b1;
    run_frames(64, 64, 16);
    check("R7 no reference", pins_o, 6'b000000);
    run_frames(65, 127, 16);
    run_frames(128, 128, 16);
    check("R7 one window after reference returns", pins_o, 6'b000000);
    run_frames(129, 191, 16);
    run_frames(0, 0, 16);
    check("R7 valid after two windows", pins_o, 6'b000011);

    // error view (R8)
    lock_lost_i = 1; parity_err_i = 1;
    frame(1'b0, 1'b0, 1'b0, 4);
    check("R8 lock loss wins", {pins_o[5:3], 3'b000}, 6'b100000);
    lock_lost_i = 0; biphase_err_i = 1; validity_i = 1;
    frame(1'b0, 1'b0, 1'b0, 4);
    check("R8 biphase over parity", {pins_o[5:3], 3'b000}, 6'b011000);
    biphase_err_i = 0;
    frame(1'b0, 1'b0, 1'b0, 4);
    check("R8 parity over validity", {pins_o[5:3], 3'b000}, 6'b010000);
    parity_err_i = 0;
    frame(1'b0, 1'b0, 1'b0, 4);
    check("R8 validity alone", {pins_o[5:3], 3'b000}, 6'b001000);
    validity_i = 0;
    frame(1'b0, 1'b0, 1'b0, 4);
    check("R8 no error", {pins_o[5:3], 3'b000}, 6'b000000);

    finish_run();
  end
endmodule